// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Hub

The hub collects up to 64 hardware interrupt lines and presents one request line to a processor. Software reaches it over a plain 32-bit register bus with a write strobe, a read strobe and a byte address. Each line has its own configuration word. That word selects rising-edge or level sensing and holds a 3-bit priority. The enable mask is changed only through set and clear registers, which come as a low half and a high half. A line counts as pending when it is enabled and either its synchronised level is high or its edge latch is set.

Reading the vector register returns the winning source number and puts the hub in service. The request output then stays low until software writes the end-of-interrupt register. A vector of 64 means nothing is pending. A soft-reset register and a global generation-enable bit complete the control set. A binding table stores a register-set number for each source and can be read back.

Top module: `irq_hub64`

## Requirements
- R1: A write to the enable-set register (low half at 0x010 for sources 0..31, high half at 0x014 for sources 32..63) enables every source whose data bit is 1. Zero bits change nothing. Reading either address returns that half of the enable mask.
- R2: A write to the disable register (low half at 0x018, high half at 0x01C) disables every source whose data bit is 1. Zero bits change nothing.
- R3: Source n has a configuration word at 0x100 + 8*n. Bit 3 selects edge sensing (1) or level sensing (0), and bits 2:0 hold the priority. The word reads back as written. Addresses between the words read 0.
- R4: A level source is pending while it is enabled and its input, delayed by the two-flop synchroniser, is high. Pending bits read at 0x020 (sources 0..31) and 0x024 (sources 32..63). A disabled source never shows pending.
- R5: An edge source latches a rising edge of its synchronised input and holds the latch after the input falls. The latch is cleared by writing its configuration word with bit 3 cleared and then writing the original word back. If the clearing write falls in the same cycle as a newly detected rise, the clear wins.
- R6: The vector register (0x000) returns the pending source with the highest priority. Ties go to the lowest source number. With nothing pending it returns 64.
- R7: irq_out is high only while bit 0 of the generation register (0x00C, readable) is 1, at least one source is pending, and the hub is not in service.
- R8: A read of the vector register that returns a value below 64 puts the hub in service and holds irq_out low. Any write to the end-of-interrupt register (0x004), whatever its data, ends service.
- R9: Writing 0x008 with bit 0 set clears enables, configuration words, edge latches, the generation bit, the in-service state and the binding table. Writing 0x008 with bit 0 clear has no effect.
- R10: A write to 0x028 stores data bits 3:0 as the register-set number of the source given in bits 13:8. That entry reads back at 0x300 + 4*source.
- R11: After hardware reset every register reads 0, the vector reads 64 and irq_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the vector read side effect) |
| addr | input | 10 | Byte address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational from addr |
| src_in | input | 64 | Asynchronous interrupt source lines |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Two events can land in the same clock edge: an edge latch can capture a freshly synchronised rise while software writes that source's configuration word with the edge bit flipped. The bench raises the input and then times the configuration write so that its strobe is sampled on the edge where the synchroniser output first shows the rise. It then restores the word and expects the high-half pending register to show the source clear, since the clear has priority. The cycle-level model in the bench follows the same rule, so the irq_out comparison made on every clock judges both orderings.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  // Register offsets (byte addresses)
  localparam logic [31:0] A_VECTOR   = 32'h000;
  localparam logic [31:0] A_EOI      = 32'h004;
  localparam logic [31:0] A_SRST     = 32'h008;
  localparam logic [31:0] A_GEN      = 32'h00C;
  localparam logic [31:0] A_ENSET_LO = 32'h010;
  localparam logic [31:0] A_ENSET_HI = 32'h014;
  localparam logic [31:0] A_DIS_LO   = 32'h018;
  localparam logic [31:0] A_DIS_HI   = 32'h01C;
  localparam logic [31:0] A_PEND_LO  = 32'h020;
  localparam logic [31:0] A_PEND_HI  = 32'h024;
  localparam logic [31:0] A_BIND_WR  = 32'h028;
  localparam logic [31:0] A_CFG_BASE = 32'h100;
  localparam logic [31:0] A_BIND_RD  = 32'h300;

  localparam logic [31:0] CFG_STRIDE  = 32'd8;
  localparam logic [31:0] BIND_STRIDE = 32'd4;
  localparam int unsigned BIND_SRC_LSB = 8;

  // True when address a hits one slot of a strided window
  function automatic logic win_hit(logic [31:0] a, logic [31:0] base,
                                   logic [31:0] count, logic [31:0] stride);
    return (a >= base) && (a < base + count * stride) &&
           (((a - base) % stride) == 32'd0);
  endfunction

  // Slot number inside a strided window
  function automatic logic [31:0] win_slot(logic [31:0] a, logic [31:0] base,
                                           logic [31:0] stride);
    return (a - base) / stride;
  endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned NSRC        = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] edge_mode,
  input  logic [NSRC-1:0] latch_clr,
  output logic [NSRC-1:0] level_now,
  output logic [NSRC-1:0] latched
);

  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_in;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= level_now;
    end
  end

  assign level_now = sync_q[SYNC_STAGES-1];
  assign rise_evt  = level_now & ~prev_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            lat_q <= 1'b0;
      else if (latch_clr[i]) lat_q <= 1'b0;
      else if (edge_mode[i]) lat_q <= lat_q | rise_evt[i];
      else                   lat_q <= 1'b0;
    end
    assign latched[i] = lat_q;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned NSRC   = 64,
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned CODE_W = 7
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [CODE_W-1:0]      win_code,
  output logic                   any
);

  always_comb begin
    logic [PRIO_W-1:0] best;
    logic              found;
    found    = 1'b0;
    best     = '0;
    win_code = CODE_W'(NSRC);
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] > best)) begin
        found    = 1'b1;
        best     = prio_flat[i*PRIO_W +: PRIO_W];
        win_code = CODE_W'(i);
      end
    end
    any = found;
  end

endmodule

// File: rtl/irq_bind_ram.sv
module irq_bind_ram #(
  parameter int unsigned NSRC  = 64,
  parameter int unsigned SET_W = 4,
  parameter int unsigned SRC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [SRC_W-1:0] wsrc,
  input  logic [SET_W-1:0] wset,
  input  logic [SRC_W-1:0] rsrc,
  output logic [SET_W-1:0] rset
);

  logic [SET_W-1:0] mem_q [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) mem_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NSRC; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[wsrc] <= wset;
    end
  end

  assign rset = mem_q[rsrc];

endmodule

// File: rtl/irq_hub64.sv
module irq_hub64 import irq_hub_pkg::*; #(
  parameter int unsigned NSRC        = 64,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned SET_W       = 4,
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_out
);

  localparam int unsigned HALF     = NSRC / 2;
  localparam int unsigned SRC_W    = $clog2(NSRC);
  localparam int unsigned CODE_W   = SRC_W + 1;
  localparam int unsigned EDGE_BIT = PRIO_W;

  logic [31:0] a_u;
  assign a_u = 32'(addr);

  // Decoded bus events, named for the checker
  logic soft_rst_hit, eoi_hit, gen_hit, bind_wr_hit;
  logic en_set_lo_hit, en_set_hi_hit, dis_lo_hit, dis_hi_hit;
  logic cfg_hit, cfg_wr_hit, bind_rd_hit, vec_rd_hit;
  logic [SRC_W-1:0] cfg_idx, bind_idx;

  assign soft_rst_hit  = wr_en && (a_u == A_SRST) && wr_data[0];
  assign eoi_hit       = wr_en && (a_u == A_EOI);
  assign gen_hit       = wr_en && (a_u == A_GEN);
  assign bind_wr_hit   = wr_en && (a_u == A_BIND_WR);
  assign en_set_lo_hit = wr_en && (a_u == A_ENSET_LO);
  assign en_set_hi_hit = wr_en && (a_u == A_ENSET_HI);
  assign dis_lo_hit    = wr_en && (a_u == A_DIS_LO);
  assign dis_hi_hit    = wr_en && (a_u == A_DIS_HI);
  assign cfg_hit       = win_hit(a_u, A_CFG_BASE, 32'(NSRC), CFG_STRIDE);
  assign cfg_wr_hit    = wr_en && cfg_hit;
  assign cfg_idx       = SRC_W'(win_slot(a_u, A_CFG_BASE, CFG_STRIDE));
  assign bind_rd_hit   = win_hit(a_u, A_BIND_RD, 32'(NSRC), BIND_STRIDE);
  assign bind_idx      = SRC_W'(win_slot(a_u, A_BIND_RD, BIND_STRIDE));

  // State
  logic [NSRC-1:0]   en_q, edge_q;
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic              gen_en, in_service;

  logic [NSRC-1:0]        level_now, latched, edge_clr, pend;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [CODE_W-1:0]      vec_code;
  logic                   any_pend;
  logic [SET_W-1:0]       bind_rset;

  assign vec_rd_hit = rd_en && (a_u == A_VECTOR) && (vec_code < CODE_W'(NSRC));

  // Enable mask
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             en_q <= '0;
    else if (soft_rst_hit)  en_q <= '0;
    else if (en_set_lo_hit) en_q[HALF-1:0]    <= en_q[HALF-1:0]    |  wr_data[HALF-1:0];
    else if (en_set_hi_hit) en_q[NSRC-1:HALF] <= en_q[NSRC-1:HALF] |  wr_data[HALF-1:0];
    else if (dis_lo_hit)    en_q[HALF-1:0]    <= en_q[HALF-1:0]    & ~wr_data[HALF-1:0];
    else if (dis_hi_hit)    en_q[NSRC-1:HALF] <= en_q[NSRC-1:HALF] & ~wr_data[HALF-1:0];
  end

  // Per-source configuration words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || soft_rst_hit) begin
      edge_q <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
    end else if (cfg_wr_hit) begin
      edge_q[cfg_idx] <= wr_data[EDGE_BIT];
      prio_q[cfg_idx] <= wr_data[PRIO_W-1:0];
    end
  end

  // Global generation enable and in-service hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_en     <= 1'b0;
      in_service <= 1'b0;
    end else if (soft_rst_hit) begin
      gen_en     <= 1'b0;
      in_service <= 1'b0;
    end else begin
      if (gen_hit)         gen_en     <= wr_data[0];
      if (vec_rd_hit)      in_service <= 1'b1;
      else if (eoi_hit)    in_service <= 1'b0;
    end
  end

  // Edge-bit change on a configuration write clears that source's latch
  for (genvar i = 0; i < NSRC; i++) begin : g_cfg
    assign edge_clr[i] = soft_rst_hit ||
                         (cfg_wr_hit && (cfg_idx == SRC_W'(i)) &&
                          (wr_data[EDGE_BIT] != edge_q[i]));
    assign prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  irq_capture #(.NSRC(NSRC), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .edge_mode(edge_q),
    .latch_clr(edge_clr), .level_now(level_now), .latched(latched)
  );

  assign pend = en_q & ((edge_q & latched) | (~edge_q & level_now));

  irq_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .CODE_W(CODE_W)) u_arb (
    .pend(pend), .prio_flat(prio_flat), .win_code(vec_code), .any(any_pend)
  );

  irq_bind_ram #(.NSRC(NSRC), .SET_W(SET_W), .SRC_W(SRC_W)) u_bind (
    .clk(clk), .rst_n(rst_n), .clr(soft_rst_hit), .we(bind_wr_hit),
    .wsrc(wr_data[BIND_SRC_LSB +: SRC_W]), .wset(wr_data[SET_W-1:0]),
    .rsrc(bind_idx), .rset(bind_rset)
  );

  assign irq_out = gen_en && any_pend && !in_service;

  // Read mux
  always_comb begin
    rd_data = '0;
    if (a_u == A_VECTOR)        rd_data = 32'(vec_code);
    else if (a_u == A_GEN)      rd_data = 32'(gen_en);
    else if (a_u == A_ENSET_LO) rd_data = 32'(en_q[HALF-1:0]);
    else if (a_u == A_ENSET_HI) rd_data = 32'(en_q[NSRC-1:HALF]);
    else if (a_u == A_PEND_LO)  rd_data = 32'(pend[HALF-1:0]);
    else if (a_u == A_PEND_HI)  rd_data = 32'(pend[NSRC-1:HALF]);
    else if (cfg_hit)           rd_data = 32'({edge_q[cfg_idx], prio_q[cfg_idx]});
    else if (bind_rd_hit)       rd_data = 32'(bind_rset);
  end

endmodule

// File: rtl/irq_hub64_chk.sv
module irq_hub64_chk #(
  parameter int unsigned NSRC = 64
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [31:0]              wr_data,
  input logic                     irq_out,
  input logic                     gen_en,
  input logic                     in_service,
  input logic                     any_pend,
  input logic [$clog2(NSRC):0]    vec_code,
  input logic [NSRC-1:0]          pend,
  input logic [NSRC-1:0]          en_q,
  input logic                     soft_rst_hit,
  input logic                     en_set_lo_hit,
  input logic                     dis_hi_hit,
  input logic                     eoi_hit
);

  localparam int unsigned HALF   = NSRC / 2;
  localparam int unsigned SRC_W  = $clog2(NSRC);
  localparam int unsigned CODE_W = SRC_W + 1;

  a_r7_irq_needs_gen: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> gen_en);

  a_r8_quiet_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |-> !irq_out);

  a_r6_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pend |-> (vec_code == CODE_W'(NSRC)));

  a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_code < CODE_W'(NSRC)) |-> pend[vec_code[SRC_W-1:0]]);

  a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_hit |=> (en_q == '0 && !gen_en && !in_service));

  a_r1_set_low: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_lo_hit |=> ((en_q[HALF-1:0] & $past(wr_data[HALF-1:0])) == $past(wr_data[HALF-1:0])));

  a_r2_clear_high: assert property (@(posedge clk) disable iff (!rst_n)
    dis_hi_hit |=> ((en_q[NSRC-1:HALF] & $past(wr_data[HALF-1:0])) == '0));

  a_r8_eoi_release: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit && !soft_rst_hit) |=> !in_service);

endmodule

bind irq_hub64 irq_hub64_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .irq_out(irq_out),
  .gen_en(gen_en), .in_service(in_service), .any_pend(any_pend),
  .vec_code(vec_code), .pend(pend), .en_q(en_q),
  .soft_rst_hit(soft_rst_hit), .en_set_lo_hit(en_set_lo_hit),
  .dis_hi_hit(dis_hi_hit), .eoi_hit(eoi_hit)
);

// File: tb/irq_hub64_test.sv
`timescale 1ns/1ps
module irq_hub64_test;
  localparam int N = 64;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [63:0] src_in = '0;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  irq_hub64 uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
                 .src_in(src_in), .irq_out(irq_out));

  always #2 clk = ~clk;

  // Behavioural reference state
  bit m_en[N], m_edge[N], m_lat[N], m_s1[N], m_s2[N], m_s3[N];
  int m_prio[N], m_bind[N];
  bit m_gen, m_svc;

  function automatic bit m_pend(int i);
    return m_en[i] && (m_edge[i] ? m_lat[i] : m_s2[i]);
  endfunction

  function automatic int m_vec();
    int best, code;
    best = -1; code = 64;
    for (int i = 0; i < N; i++)
      if (m_pend(i) && m_prio[i] > best) begin best = m_prio[i]; code = i; end
    return code;
  endfunction

  function automatic bit m_irq();
    return m_gen && (m_vec() < 64) && !m_svc;
  endfunction

  function automatic logic [31:0] m_read(int a);
    logic [31:0] r;
    r = '0;
    if (a == 'h000) r = 32'(m_vec());
    else if (a == 'h00C) r = 32'(m_gen);
    else if (a == 'h010) for (int i = 0; i < 32; i++) r[i] = m_en[i];
    else if (a == 'h014) for (int i = 0; i < 32; i++) r[i] = m_en[i+32];
    else if (a == 'h020) for (int i = 0; i < 32; i++) r[i] = m_pend(i);
    else if (a == 'h024) for (int i = 0; i < 32; i++) r[i] = m_pend(i+32);
    else if (a >= 'h100 && a < 'h300 && a % 8 == 0)
      r = 32'(m_edge[(a-'h100)/8]) << 3 | 32'(m_prio[(a-'h100)/8]);
    else if (a >= 'h300 && a < 'h400 && a % 4 == 0) r = 32'(m_bind[(a-'h300)/4]);
    return r;
  endfunction

  always @(posedge clk) begin
    int a, v, ci;
    bit srst, cfgw, rise, clr;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_en[i] = 0; m_edge[i] = 0; m_lat[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
        m_s3[i] = 0; m_prio[i] = 0; m_bind[i] = 0;
      end
      m_gen = 0; m_svc = 0;
    end else begin
      a    = int'(addr);
      v    = m_vec();
      srst = wr_en && a == 'h008 && wr_data[0];
      cfgw = wr_en && a >= 'h100 && a < 'h300 && a % 8 == 0;
      ci   = (a - 'h100) / 8;
      for (int i = 0; i < N; i++) begin
        rise = m_s2[i] && !m_s3[i];
        clr  = srst || (cfgw && ci == i && wr_data[3] != m_edge[i]);
        if (clr) m_lat[i] = 0;
        else if (m_edge[i]) m_lat[i] = m_lat[i] | rise;
        else m_lat[i] = 0;
        m_s3[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = src_in[i];
      end
      if (srst) begin
        for (int i = 0; i < N; i++) begin
          m_en[i] = 0; m_edge[i] = 0; m_prio[i] = 0; m_bind[i] = 0;
        end
        m_gen = 0; m_svc = 0;
      end else begin
        if (wr_en) begin
          if (a == 'h004) m_svc = 0;
          if (a == 'h00C) m_gen = wr_data[0];
          if (a == 'h010) for (int i = 0; i < 32; i++) if (wr_data[i]) m_en[i] = 1;
          if (a == 'h014) for (int i = 0; i < 32; i++) if (wr_data[i]) m_en[i+32] = 1;
          if (a == 'h018) for (int i = 0; i < 32; i++) if (wr_data[i]) m_en[i] = 0;
          if (a == 'h01C) for (int i = 0; i < 32; i++) if (wr_data[i]) m_en[i+32] = 0;
          if (a == 'h028) m_bind[wr_data[13:8]] = int'(wr_data[3:0]);
        end
        if (cfgw) begin m_edge[ci] = wr_data[3]; m_prio[ci] = int'(wr_data[2:0]); end
        if (rd_en && a == 'h000 && v < 64) m_svc = 1;
      end
    end
  end

  // Per-clock comparison of the request line (R7, R8)
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (irq_out !== m_irq()) begin
        fails++;
        $display("FAIL R7 irq_out at %0t actual=%0b expected=%0b", $time, irq_out, m_irq());
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = a[9:0]; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Literal expectation plus reference-model expectation
  task automatic rd_lit(input int a, input logic [31:0] exp, input string tag);
    logic [31:0] m;
    @(negedge clk); addr = a[9:0]; rd_en = 1'b1;
    #1;
    m = m_read(a);
    checks += 2;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, a, rd_data, exp);
    end
    if (rd_data !== m) begin
      fails++;
      $display("FAIL %s model addr=%0h actual=%0h expected=%0h", tag, a, rd_data, m);
    end
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk); #1;
    checks++;
    if (irq_out !== exp) begin
      fails++;
      $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, exp);
    end
  endtask

  task automatic set_src(input int i, input logic v);
    @(negedge clk); src_in[i] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd_lit('h000, 64, "R11");
    rd_lit('h010, 0, "R11");
    rd_lit('h00C, 0, "R11");
    chk_irq(1'b0, "R11");

    // R1: set halves, zero bits keep state
    wr('h010, 32'h5);
    wr('h014, 32'h8000_0001);
    rd_lit('h010, 32'h5, "R1");
    rd_lit('h014, 32'h8000_0001, "R1");
    wr('h010, 32'h2);
    rd_lit('h010, 32'h7, "R1");

    // R2: disable halves
    wr('h018, 32'h1);
    rd_lit('h010, 32'h6, "R2");
    wr('h01C, 32'h0);
    rd_lit('h014, 32'h8000_0001, "R2");
    wr('h01C, 32'h1);
    rd_lit('h014, 32'h8000_0000, "R2");

    // R3: configuration words at stride 8
    wr('h100 + 5*8, 32'h6);
    wr('h100 + 33*8, 32'hA);
    rd_lit('h128, 32'h6, "R3");
    rd_lit('h208, 32'hA, "R3");
    rd_lit('h10C, 32'h0, "R3");

    // R4: level source, and a disabled one
    set_src(1, 1'b1); idle(3);
    rd_lit('h020, 32'h2, "R4");
    set_src(3, 1'b1); idle(3);
    rd_lit('h020, 32'h2, "R4 disabled source");

    // R7: generation enable gates the request
    chk_irq(1'b0, "R7 gen off");
    wr('h00C, 32'h1);
    rd_lit('h00C, 32'h1, "R7");
    chk_irq(1'b1, "R7 gen on");

    // R6 / R8: vector read, service hold, end of interrupt
    rd_lit('h000, 1, "R6");
    chk_irq(1'b0, "R8 in service");
    wr('h004, 32'hDEAD_BEEF);
    chk_irq(1'b1, "R8 eoi");
    wr('h010, 32'h20);
    set_src(5, 1'b1); idle(3);
    rd_lit('h000, 5, "R6 priority");
    wr('h004, 32'h0);
    wr('h110, 32'h6);
    set_src(2, 1'b1); idle(3);
    rd_lit('h000, 2, "R6 tie lowest");
    wr('h004, 32'h0);
    wr('h100 + 63*8, 32'h7);
    set_src(63, 1'b1); idle(3);
    rd_lit('h000, 63, "R6 top");
    wr('h004, 32'h0);

    // R5: edge latch and toggle clear
    wr('h014, 32'h2);
    set_src(33, 1'b1); idle(2);
    set_src(33, 1'b0); idle(4);
    rd_lit('h024, 32'h8000_0002, "R5 latched");
    wr('h208, 32'h2);
    wr('h208, 32'hA);
    rd_lit('h024, 32'h8000_0000, "R5 cleared");

    // R5: clear in the same cycle as a detected rise
    @(negedge clk); src_in[33] = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 10'h208; wr_data = 32'h2; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    wr('h208, 32'hA);
    idle(3);
    rd_lit('h024, 32'h8000_0000, "R5 clear wins");
    set_src(33, 1'b0); idle(3);

    // R10: binding table
    wr('h028, (17 << 8) | 9);
    rd_lit('h300 + 17*4, 9, "R10");
    wr('h028, (0 << 8) | 15);
    rd_lit('h300, 15, "R10");

    // R9: soft reset, with bit 0 clear first
    wr('h008, 32'h0);
    rd_lit('h010, 32'h26, "R9 no effect");
    wr('h008, 32'h1);
    rd_lit('h010, 0, "R9");
    rd_lit('h014, 0, "R9");
    rd_lit('h344, 0, "R9");
    rd_lit('h128, 0, "R9");
    rd_lit('h00C, 0, "R9");
    rd_lit('h000, 64, "R9");
    chk_irq(1'b0, "R9");

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

endmodule